// File: doc/BRIEF.md
# NAND Asynchronous Bus Timing Generator

This block drives the strobes of an asynchronous NAND flash bus: one chip enable per bank, the command and address latch enables, the write strobe and the read strobe. It also drives the write data and samples the read data. Each request is one bus cycle of four kinds: command, address, data write or data read. A request enters through a valid/ready handshake and is accepted only while the sequencer is idle. Every duration is a count of interface clocks read from configuration inputs. These are the strobe low time, the strobe high time, the read sample delay, the chip-enable setup and four turnaround gaps.

A count of zero is treated as one clock, and each count is clamped to the largest value its field can hold. The address-to-data gap has a narrow mode in which its ceiling is 63 rather than 127. The effective low time is raised when needed, so that low plus high is never shorter than six clocks. A gap is inserted before a strobe only when a request follows an earlier cycle on the same bank while the chip enable is still held. Its length depends on the kinds of the previous and the next cycle.

Top module: `nand_bus_timer`

## Requirements
- R1: The active strobe stays low for L clocks. L = max(norm(cfg_lo_cnt), 6 - H), where norm(x) is 1 for x = 0, x clamped to the field maximum otherwise, and H = norm(cfg_hi_cnt).
- R2: After the low phase the strobe stays high for H clocks. The block then returns to idle with req_ready high. L + H is always at least 6.
- R3: Command (req_kind 0), address (1) and data-write (2) cycles pulse we_n. Data-read (3) cycles pulse re_n. The two strobes are never low at the same time.
- R4: cle is high only for command cycles and ale only for address cycles. Neither changes while a strobe is low or during the high phase that follows.
- R5: A request that opens a session (no chip enable held, or a different bank from the held one) asserts ce_n[req_bank] and waits norm(cfg_ce_setup) clocks before the strobe falls. No turnaround gap is added.
- R6: Within a session, a read followed by a command, address or write waits norm(cfg_rd2wr_gap) clocks before the strobe falls. A read followed by a read waits norm(cfg_rd2rd_gap).
- R7: Within a session, a command or write followed by a read waits norm(cfg_wr2rd_gap) clocks.
- R8: Within a session, an address followed by a data cycle of either direction waits norm(cfg_adr2dat_gap). This rule takes priority over R7. With cfg_narrow_a2d high, the value is clamped to 63. All other pairs of cycle kinds have no gap.
- R9: For a read, dq_in is captured at the clock edge that ends clock S of the strobe cycle, counting the first low clock as 1. S = min(norm(cfg_acc_cnt), L + H). rd_data carries the value and rd_valid pulses high for exactly the next clock.
- R10: At most one ce_n bit is low. A chip enable stays low between back-to-back requests to the same bank. It is released one clock after an idle cycle in which req_valid is low.
- R11: req_ready is high only when idle, and no strobe is then low. For command, address and write cycles, dq_oe is high and dq_out equals the request data during the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_lo_cnt | input | STRB_W | Strobe low clocks |
| cfg_hi_cnt | input | STRB_W | Strobe high clocks |
| cfg_acc_cnt | input | ACC_W | Clocks from read strobe fall to sample |
| cfg_rd2wr_gap | input | GAP_W | Gap for read followed by a write-type cycle |
| cfg_rd2rd_gap | input | GAP_W | Gap for read followed by read |
| cfg_wr2rd_gap | input | GAP_W | Gap for command/write followed by read |
| cfg_adr2dat_gap | input | A2D_W | Gap for address followed by data |
| cfg_ce_setup | input | CS_W | Chip-enable setup clocks before the first strobe |
| cfg_narrow_a2d | input | 1 | Clamp the address-to-data gap to 6 bits |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_kind | input | 2 | 0 command, 1 address, 2 write data, 3 read data |
| req_bank | input | BANK_W | Target bank |
| req_wdata | input | DW | Byte for command, address or write |
| ce_n | output | NBANK | Chip enables, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| dq_out | output | DW | Bus data driven out |
| dq_oe | output | 1 | Bus output enable |
| dq_in | input | DW | Bus data in |
| rd_valid | output | 1 | One-clock pulse with sampled read data |
| rd_data | output | DW | Sampled read byte |

## Verification
A miscounted phase counter shows as a strobe low or high run one clock too long or too short. It also moves the rd_data capture, which then holds the byte from a neighbouring clock. All of this is visible within the same bus cycle. If the session tracking is stuck, the wrong pre-strobe wait appears on the very next request: a setup delay where a turnaround gap belongs, or the reverse. A chip enable left asserted is seen one clock after the idle cycle. A wrong gap selection for a cycle-kind pair shows as a different number of high clocks before the strobe falls.

// File: rtl/nbt_pkg.sv
package nbt_pkg;

    localparam int NBT_CW        = 8;
    localparam int NBT_MIN_CYCLE = 6;

    typedef enum logic [1:0] {
        CY_CMD   = 2'd0,
        CY_ADDR  = 2'd1,
        CY_WDATA = 2'd2,
        CY_RDATA = 2'd3
    } cyc_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_GAP,
        ST_LOW,
        ST_HIGH
    } seq_st_e;

    typedef struct packed {
        logic [NBT_CW-1:0] lo;
        logic [NBT_CW-1:0] hi;
        logic [NBT_CW-1:0] smp;
        logic [NBT_CW-1:0] rd2wr;
        logic [NBT_CW-1:0] rd2rd;
        logic [NBT_CW-1:0] wr2rd;
        logic [NBT_CW-1:0] a2d;
        logic [NBT_CW-1:0] cs;
    } timing_t;

    // Zero means one clock; anything above the ceiling is held at the ceiling.
    function automatic logic [NBT_CW-1:0] norm_cnt(input logic [NBT_CW-1:0] v,
                                                   input logic [NBT_CW-1:0] mx);
        if (v == '0)
            return NBT_CW'(1);
        if (v > mx)
            return mx;
        return v;
    endfunction

    function automatic logic is_write_kind(input cyc_e k);
        return k != CY_RDATA;
    endfunction

endpackage

// File: rtl/nbt_cfg_norm.sv
module nbt_cfg_norm
    import nbt_pkg::*;
#(
    parameter int STRB_W  = 4,
    parameter int ACC_W   = 4,
    parameter int GAP_W   = 5,
    parameter int A2D_W   = 7,
    parameter int CS_W    = 4,
    parameter int MIN_CYC = NBT_MIN_CYCLE
) (
    input  logic [STRB_W-1:0] lo_raw,
    input  logic [STRB_W-1:0] hi_raw,
    input  logic [ACC_W-1:0]  acc_raw,
    input  logic [GAP_W-1:0]  rd2wr_raw,
    input  logic [GAP_W-1:0]  rd2rd_raw,
    input  logic [GAP_W-1:0]  wr2rd_raw,
    input  logic [A2D_W-1:0]  a2d_raw,
    input  logic [CS_W-1:0]   cs_raw,
    input  logic              narrow_a2d,
    output timing_t           tm
);
    localparam logic [NBT_CW-1:0] STRB_MAX   = NBT_CW'((1 << STRB_W) - 1);
    localparam logic [NBT_CW-1:0] ACC_MAX    = NBT_CW'((1 << ACC_W) - 1);
    localparam logic [NBT_CW-1:0] GAP_MAX    = NBT_CW'((1 << GAP_W) - 1);
    localparam logic [NBT_CW-1:0] A2D_MAX    = NBT_CW'((1 << A2D_W) - 1);
    localparam logic [NBT_CW-1:0] A2D_MAX_NR = NBT_CW'((1 << (A2D_W - 1)) - 1);
    localparam logic [NBT_CW-1:0] CS_MAX     = NBT_CW'((1 << CS_W) - 1);
    localparam logic [NBT_CW-1:0] MIN_C      = NBT_CW'(MIN_CYC);

    logic [NBT_CW-1:0] lo_n, hi_n, acc_n, floor_lo, lo_e, total;

    always_comb begin
        hi_n     = norm_cnt(NBT_CW'(hi_raw), STRB_MAX);
        lo_n     = norm_cnt(NBT_CW'(lo_raw), STRB_MAX);
        acc_n    = norm_cnt(NBT_CW'(acc_raw), ACC_MAX);
        floor_lo = (MIN_C > hi_n) ? (MIN_C - hi_n) : NBT_CW'(0);
        lo_e     = (lo_n < floor_lo) ? floor_lo : lo_n;
        total    = lo_e + hi_n;

        tm.lo    = lo_e;
        tm.hi    = hi_n;
        tm.smp   = (acc_n > total) ? total : acc_n;
        tm.rd2wr = norm_cnt(NBT_CW'(rd2wr_raw), GAP_MAX);
        tm.rd2rd = norm_cnt(NBT_CW'(rd2rd_raw), GAP_MAX);
        tm.wr2rd = norm_cnt(NBT_CW'(wr2rd_raw), GAP_MAX);
        tm.a2d   = norm_cnt(NBT_CW'(a2d_raw), narrow_a2d ? A2D_MAX_NR : A2D_MAX);
        tm.cs    = norm_cnt(NBT_CW'(cs_raw), CS_MAX);
    end
endmodule

// File: rtl/nbt_gap_sel.sv
module nbt_gap_sel
    import nbt_pkg::*;
(
    input  timing_t           tm,
    input  logic              prev_valid,
    input  cyc_e              prev_kind,
    input  cyc_e              next_kind,
    output logic              gap_need,
    output logic [NBT_CW-1:0] gap_len
);
    logic next_is_data;

    always_comb begin
        next_is_data = (next_kind == CY_WDATA) || (next_kind == CY_RDATA);
        gap_need     = 1'b0;
        gap_len      = NBT_CW'(1);
        if (prev_valid) begin
            if (prev_kind == CY_ADDR && next_is_data) begin
                gap_need = 1'b1;
                gap_len  = tm.a2d;
            end else if (prev_kind == CY_RDATA && next_kind == CY_RDATA) begin
                gap_need = 1'b1;
                gap_len  = tm.rd2rd;
            end else if (prev_kind == CY_RDATA) begin
                gap_need = 1'b1;
                gap_len  = tm.rd2wr;
            end else if ((prev_kind == CY_CMD || prev_kind == CY_WDATA)
                         && next_kind == CY_RDATA) begin
                gap_need = 1'b1;
                gap_len  = tm.wr2rd;
            end
        end
    end
endmodule

// File: rtl/nbt_seq.sv
module nbt_seq
    import nbt_pkg::*;
#(
    parameter int DW     = 8,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  timing_t           tm,
    input  logic              req_valid,
    input  cyc_e              req_kind,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [DW-1:0]     req_wdata,
    input  logic [DW-1:0]     dq_in,
    input  logic              gap_need,
    input  logic [NBT_CW-1:0] gap_len,
    output logic              req_ready,
    output logic              prev_valid,
    output cyc_e              prev_kind,
    output logic              ce_act,
    output logic [BANK_W-1:0] cur_bank,
    output logic              cle,
    output logic              ale,
    output logic              we_n,
    output logic              re_n,
    output logic [DW-1:0]     dq_out,
    output logic              dq_oe,
    output logic              rd_valid,
    output logic [DW-1:0]     rd_data
);
    seq_st_e           state;
    logic [NBT_CW-1:0] cnt;
    logic [NBT_CW-1:0] ph;
    cyc_e              cur_kind;
    logic [DW-1:0]     cur_data;
    logic              new_sess;
    logic              in_strobe;
    logic              smp_hit;
    logic              last_cnt;

    always_comb begin
        new_sess  = !ce_act || (req_bank != cur_bank);
        in_strobe = (state == ST_LOW) || (state == ST_HIGH);
        smp_hit   = in_strobe && (cur_kind == CY_RDATA)
                    && (ph == tm.smp - NBT_CW'(1));
        last_cnt  = (cnt == NBT_CW'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            ph         <= '0;
            cur_kind   <= CY_CMD;
            cur_bank   <= '0;
            cur_data   <= '0;
            ce_act     <= 1'b0;
            prev_valid <= 1'b0;
            prev_kind  <= CY_CMD;
            rd_valid   <= 1'b0;
            rd_data    <= '0;
        end else begin
            rd_valid <= smp_hit;
            if (smp_hit)
                rd_data <= dq_in;

            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        cur_kind <= req_kind;
                        cur_bank <= req_bank;
                        cur_data <= req_wdata;
                        ce_act   <= 1'b1;
                        if (new_sess) begin
                            state      <= ST_SETUP;
                            cnt        <= tm.cs;
                            prev_valid <= 1'b0;
                        end else if (gap_need) begin
                            state <= ST_GAP;
                            cnt   <= gap_len;
                        end else begin
                            state <= ST_LOW;
                            cnt   <= tm.lo;
                            ph    <= '0;
                        end
                    end else begin
                        ce_act     <= 1'b0;
                        prev_valid <= 1'b0;
                    end
                end
                ST_SETUP, ST_GAP: begin
                    if (last_cnt) begin
                        state <= ST_LOW;
                        cnt   <= tm.lo;
                        ph    <= '0;
                    end else begin
                        cnt <= cnt - NBT_CW'(1);
                    end
                end
                ST_LOW: begin
                    ph <= ph + NBT_CW'(1);
                    if (last_cnt) begin
                        state <= ST_HIGH;
                        cnt   <= tm.hi;
                    end else begin
                        cnt <= cnt - NBT_CW'(1);
                    end
                end
                ST_HIGH: begin
                    ph <= ph + NBT_CW'(1);
                    if (last_cnt) begin
                        state      <= ST_IDLE;
                        prev_valid <= 1'b1;
                        prev_kind  <= cur_kind;
                    end else begin
                        cnt <= cnt - NBT_CW'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready = (state == ST_IDLE);
        we_n      = !((state == ST_LOW) && is_write_kind(cur_kind));
        re_n      = !((state == ST_LOW) && (cur_kind == CY_RDATA));
        cle       = (state != ST_IDLE) && (cur_kind == CY_CMD);
        ale       = (state != ST_IDLE) && (cur_kind == CY_ADDR);
        dq_oe     = (state != ST_IDLE) && is_write_kind(cur_kind);
        dq_out    = cur_data;
    end
endmodule

// File: rtl/nand_bus_timer.sv
module nand_bus_timer
    import nbt_pkg::*;
#(
    parameter int NBANK   = 4,
    parameter int DW      = 8,
    parameter int STRB_W  = 4,
    parameter int ACC_W   = 4,
    parameter int GAP_W   = 5,
    parameter int A2D_W   = 7,
    parameter int CS_W    = 4,
    parameter int MIN_CYC = NBT_MIN_CYCLE,
    localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STRB_W-1:0] cfg_lo_cnt,
    input  logic [STRB_W-1:0] cfg_hi_cnt,
    input  logic [ACC_W-1:0]  cfg_acc_cnt,
    input  logic [GAP_W-1:0]  cfg_rd2wr_gap,
    input  logic [GAP_W-1:0]  cfg_rd2rd_gap,
    input  logic [GAP_W-1:0]  cfg_wr2rd_gap,
    input  logic [A2D_W-1:0]  cfg_adr2dat_gap,
    input  logic [CS_W-1:0]   cfg_ce_setup,
    input  logic              cfg_narrow_a2d,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [DW-1:0]     req_wdata,
    output logic [NBANK-1:0]  ce_n,
    output logic              cle,
    output logic              ale,
    output logic              we_n,
    output logic              re_n,
    output logic [DW-1:0]     dq_out,
    output logic              dq_oe,
    input  logic [DW-1:0]     dq_in,
    output logic              rd_valid,
    output logic [DW-1:0]     rd_data
);
    timing_t           tm;
    logic              gap_need;
    logic [NBT_CW-1:0] gap_len;
    logic              prev_valid;
    cyc_e              prev_kind;
    logic              ce_act;
    logic [BANK_W-1:0] cur_bank;

    nbt_cfg_norm #(
        .STRB_W(STRB_W), .ACC_W(ACC_W), .GAP_W(GAP_W),
        .A2D_W(A2D_W), .CS_W(CS_W), .MIN_CYC(MIN_CYC)
    ) u_norm (
        .lo_raw    (cfg_lo_cnt),
        .hi_raw    (cfg_hi_cnt),
        .acc_raw   (cfg_acc_cnt),
        .rd2wr_raw (cfg_rd2wr_gap),
        .rd2rd_raw (cfg_rd2rd_gap),
        .wr2rd_raw (cfg_wr2rd_gap),
        .a2d_raw   (cfg_adr2dat_gap),
        .cs_raw    (cfg_ce_setup),
        .narrow_a2d(cfg_narrow_a2d),
        .tm        (tm)
    );

    nbt_gap_sel u_gap (
        .tm        (tm),
        .prev_valid(prev_valid),
        .prev_kind (prev_kind),
        .next_kind (cyc_e'(req_kind)),
        .gap_need  (gap_need),
        .gap_len   (gap_len)
    );

    nbt_seq #(.DW(DW), .BANK_W(BANK_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .tm        (tm),
        .req_valid (req_valid),
        .req_kind  (cyc_e'(req_kind)),
        .req_bank  (req_bank),
        .req_wdata (req_wdata),
        .dq_in     (dq_in),
        .gap_need  (gap_need),
        .gap_len   (gap_len),
        .req_ready (req_ready),
        .prev_valid(prev_valid),
        .prev_kind (prev_kind),
        .ce_act    (ce_act),
        .cur_bank  (cur_bank),
        .cle       (cle),
        .ale       (ale),
        .we_n      (we_n),
        .re_n      (re_n),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_ce
        assign ce_n[b] = !(ce_act && (cur_bank == BANK_W'(b)));
    end
endmodule

// File: rtl/nbt_checker.sv
module nbt_checker #(
    parameter int NBANK = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             we_n,
    input logic             re_n,
    input logic             cle,
    input logic             ale,
    input logic [NBANK-1:0] ce_n,
    input logic             req_ready,
    input logic             rd_valid,
    input logic             dq_oe
);
    assert_one_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        !(!we_n && !re_n));

    assert_latch_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(cle && ale));

    assert_latch_stable_R4: assert property (@(posedge clk) disable iff (rst)
        (!we_n && $past(!we_n)) |-> ($stable(cle) && $stable(ale)));

    assert_ce_onehot_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~ce_n));

    assert_strobe_has_ce_R5: assert property (@(posedge clk) disable iff (rst)
        (!we_n || !re_n) |-> (ce_n != '1));

    assert_rd_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (we_n && re_n && !dq_oe));

    assert_write_drives_R11: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> dq_oe);
endmodule

bind nand_bus_timer nbt_checker #(.NBANK(NBANK)) u_nbt_checker (
    .clk      (clk),
    .rst      (rst),
    .we_n     (we_n),
    .re_n     (re_n),
    .cle      (cle),
    .ale      (ale),
    .ce_n     (ce_n),
    .req_ready(req_ready),
    .rd_valid (rd_valid),
    .dq_oe    (dq_oe)
);

// File: tb/nand_bus_timer_bench.sv
module nand_bus_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NBANK = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] cfg_lo = 4'd3, cfg_hi = 4'd3, cfg_acc = 4'd2;
    logic [4:0] cfg_r2w = 5'd2, cfg_r2r = 5'd2, cfg_w2r = 5'd2;
    logic [6:0] cfg_a2d = 7'd2;
    logic [3:0] cfg_cs = 4'd1;
    logic       cfg_nar = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_kind = 2'd0;
    logic [1:0] req_bank = 2'd0;
    logic [7:0] req_wdata = 8'd0;
    logic [NBANK-1:0] ce_n;
    logic cle, ale, we_n, re_n, dq_oe, rd_valid;
    logic [7:0] dq_out, rd_data, dq_in;

    int tick = 0;
    int n_chk = 0, n_bad = 0;
    bit done = 0;
    bit sess_on = 0, pv = 0;
    int sess_bank = 0, pk = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) tick <= tick + 1;
    assign dq_in = tick[7:0];

    nand_bus_timer u_nand_bus_timer (
        .clk(clk), .rst(rst),
        .cfg_lo_cnt(cfg_lo), .cfg_hi_cnt(cfg_hi), .cfg_acc_cnt(cfg_acc),
        .cfg_rd2wr_gap(cfg_r2w), .cfg_rd2rd_gap(cfg_r2r), .cfg_wr2rd_gap(cfg_w2r),
        .cfg_adr2dat_gap(cfg_a2d), .cfg_ce_setup(cfg_cs), .cfg_narrow_a2d(cfg_nar),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_bank(req_bank), .req_wdata(req_wdata),
        .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n),
        .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff(input int v, input int mx);
        if (v == 0) return 1;
        if (v > mx) return mx;
        return v;
    endfunction

    function automatic int hi_e();
        return eff(cfg_hi, 15);
    endfunction

    function automatic int lo_e();
        int l = eff(cfg_lo, 15);
        int f = 6 - hi_e();
        return (l < f) ? f : l;
    endfunction

    function automatic int smp_e();
        int a = eff(cfg_acc, 15);
        int t = lo_e() + hi_e();
        return (a > t) ? t : a;
    endfunction

    function automatic int gap_e(input int prev, input int nxt);
        if (prev == 1 && (nxt == 2 || nxt == 3)) return eff(cfg_a2d, cfg_nar ? 63 : 127);
        if (prev == 3 && nxt == 3) return eff(cfg_r2r, 31);
        if (prev == 3) return eff(cfg_r2w, 31);
        if ((prev == 0 || prev == 2) && nxt == 3) return eff(cfg_w2r, 31);
        return 0;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // One bus cycle; called at a sample point where req_ready is high.
    task automatic run_req(input int kind, input int bank, input int data);
        bit new_sess = !sess_on || (bank != sess_bank);
        int exp_pre = new_sess ? eff(cfg_cs, 15) : (pv ? gap_e(pk, kind) : 0);
        int pre = 0, low = 0, hi = 0, phase = 0, fall = 0, guard = 0;
        int rd_seen = 0, rd_tick = 0, rd_got = 0;
        bit bad_strb = 0, bad_lat = 0, bad_ce = 0, bad_dq = 0;
        string tag;
        tag = (kind == 3) ? "R3 read strobe" : "R3 write strobe";
        req_valid = 1; req_kind = 2'(kind); req_bank = 2'(bank); req_wdata = 8'(data);
        @(posedge clk); @(negedge clk); #1;
        req_valid = 0;
        forever begin
            if (rd_valid) begin rd_seen++; rd_tick = tick; rd_got = rd_data; end
            if (phase == 0) begin
                if (we_n && re_n) pre++;
                else begin phase = 1; fall = tick; end
            end
            if (phase == 1) begin
                if (!we_n || !re_n) begin
                    low++;
                    if (kind == 3 ? (re_n || !we_n) : (we_n || !re_n)) bad_strb = 1;
                    if (kind != 3 && (!dq_oe || dq_out != 8'(data))) bad_dq = 1;
                end else phase = 2;
            end
            if (phase == 2) begin
                if (req_ready) break;
                hi++;
            end
            if (phase != 0) begin
                if (cle != (kind == 0) || ale != (kind == 1)) bad_lat = 1;
                if (ce_n[bank] != 1'b0) bad_ce = 1;
            end
            guard++;
            if (guard > 600) break;
            @(negedge clk); #1;
        end
        check(pre == exp_pre, new_sess ? "R5 ce setup" : "R6/R7/R8 turnaround", pre, exp_pre);
        check(low == lo_e(), "R1 low count", low, lo_e());
        check(hi == hi_e(), "R2 high count", hi, hi_e());
        check(low + hi >= 6, "R2 min cycle", low + hi, 6);
        check(!bad_strb, tag, bad_strb, 0);
        check(!bad_lat, "R4 cle/ale", bad_lat, 0);
        check(!bad_ce && ce_n[bank] == 1'b0, "R10 ce held", bad_ce, 0);
        if (kind != 3) begin
            check(!bad_dq, "R11 write data", bad_dq, 0);
            check(rd_seen == 0, "R9 no read pulse on write", rd_seen, 0);
        end else begin
            check(rd_seen == 1, "R9 pulse count", rd_seen, 1);
            check(rd_tick == fall + smp_e(), "R9 pulse time", rd_tick, fall + smp_e());
            check(rd_got == ((fall + smp_e() - 1) & 8'hFF), "R9 sample",
                  rd_got, (fall + smp_e() - 1) & 8'hFF);
        end
        sess_on = 1; sess_bank = bank; pv = 1; pk = kind;
    endtask

    task automatic go_idle();
        req_valid = 0;
        @(negedge clk); #1;
        check(ce_n == '1, "R10 ce released", int'(ce_n), 'hF);
        check(req_ready == 1'b1, "R11 ready idle", req_ready, 1);
        sess_on = 0; pv = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED1234));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk); #1;
        check(ce_n == '1 && we_n && re_n && !cle && !ale, "R10 reset outputs", int'(ce_n), 'hF);
        check(req_ready && !rd_valid && !dq_oe, "R11 reset ready", req_ready, 1);

        // Directed: zero counts, floor raising the low time (R1/R2).
        cfg_lo = 0; cfg_hi = 0; cfg_cs = 0; cfg_acc = 0;
        run_req(0, 1, 8'h70);          // R5 setup of one clock, R1 low raised to 5
        cfg_lo = 2; cfg_hi = 2;
        run_req(1, 1, 8'h12);          // R1 low raised to 4
        cfg_w2r = 0; cfg_a2d = 5;
        run_req(3, 1, 0);              // R8 address then read uses a2d
        cfg_r2r = 0;
        run_req(3, 1, 0);              // R6 read-read with zero field = 1
        cfg_r2w = 7;
        run_req(2, 1, 8'hA5);          // R6 read-write
        cfg_w2r = 4; cfg_acc = 15; cfg_lo = 3; cfg_hi = 3;
        run_req(3, 1, 0);              // R7 write-read, R9 sample capped at 6
        run_req(0, 1, 8'h30);          // read then command: R6
        run_req(0, 1, 8'h31);          // command-command: no gap
        run_req(1, 1, 8'h00);          // command-address: no gap
        cfg_a2d = 100; cfg_nar = 1;
        run_req(2, 1, 8'h5A);          // R8 narrow clamp to 63
        run_req(1, 1, 8'h01);
        cfg_nar = 0;
        run_req(2, 1, 8'h5B);          // R8 wide keeps 100
        run_req(2, 2, 8'h5C);          // R5 bank change opens a session
        go_idle();
        cfg_cs = 9;
        run_req(3, 0, 0);              // R5 setup after idle
        go_idle();

        // Random phase.
        for (int i = 0; i < 220; i++) begin
            if ($urandom_range(0, 3) == 0) begin
                cfg_lo = 4'($urandom); cfg_hi = 4'($urandom); cfg_acc = 4'($urandom);
                cfg_r2w = 5'($urandom); cfg_r2r = 5'($urandom); cfg_w2r = 5'($urandom);
                cfg_a2d = 7'($urandom_range(0, 127)); cfg_cs = 4'($urandom);
                cfg_nar = 1'($urandom);
            end
            if ($urandom_range(0, 7) == 0) go_idle();
            run_req($urandom_range(0, 3),
                    ($urandom_range(0, 4) == 0) ? $urandom_range(0, NBANK - 1) : sess_bank,
                    $urandom_range(0, 255));
        end
        go_idle();
        finish_run();
    end
endmodule